// File: doc/BRIEF.md
# Eleven-Level Phase-Shifted Carrier Modulator

This block drives one leg of an eleven-level hybrid multicell inverter. It takes a signed fixed-point reference in the range −5 to +5 output steps and produces five registered switch commands:

- a polarity switch,
- a minor-step switch and its complement,
- two cell switches that build the even part of the level.

It generates all its carriers internally from its clock. A single phase counter with period `2*2^FRAC_W` cycles feeds seven up/down triangles:

- five magnitude carriers, spaced by a fifth of a period and stacked one step apart in amplitude;
- two cell carriers, half a period apart.

The magnitude of the sampled reference is compared against the five stacked carriers, and the comparator outputs are summed into a staircase value from 0 to 5. A negative reference folds the staircase as `5 - staircase`. The folded value then splits two ways: its upper bits form the even major part (0, 2 or 4), which the cell modulator turns into the two cell switches, and its lowest bit is the minor step. The reference is taken once per carrier period, at the top of the first magnitude carrier, so each period applies one settled value.

Top module: `ml11_modulator`

## Requirements
- R1: While `rst_ni` is low the outputs are `pol_o=0`, `minor_o=0`, `minor_n_o=1`, `cell_hi_o=0`, `cell_lo_o=0`, which is output level 0.
- R2: `ref_i` is loaded only on the clock edge that ends phase count `2^FRAC_W - 1`. Phase counting starts at 0 on reset release and advances on every edge. The outputs first reflect a new value on the edge after that load, and a change at any other time has no effect until then.
- R3: Let `M = min(|ref|, 5*2^FRAC_W)`. In every cycle the magnitude of the output level equals either `floor(M/2^FRAC_W)` or `ceil(M/2^FRAC_W)`.
- R4: With the reference held, the output level summed over any `2^(FRAC_W+1)` consecutive cycles equals `2*clamp(ref, -5*2^FRAC_W, 5*2^FRAC_W)`.
- R5: A reference beyond ±5 steps saturates, and the output then stays at level +5 or −5 in every cycle.
- R6: `pol_o` is 1 in every cycle in which the applied reference is negative, and 0 otherwise, including for a zero reference.
- R7: `minor_n_o` is always the inverse of `minor_o`.
- R8: The output level is `2*(cell_hi_o + cell_lo_o) + minor_o - 5*pol_o`. Levels +5, +4, −4 and −5 use the single states (`pol`, `minor`, `cell_hi`, `cell_lo`) 0111, 0011, 1100 and 1000. A negative reference reaches level 0 only through state 1111.
- R9: When the even major part is held at 2, the cell pair alternates between 01 and 10, each for half of every carrier period, and never shows 00 or 11.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Carrier clock; one phase count per edge |
| rst_ni | input | 1 | Active-low asynchronous reset |
| ref_i | input | FRAC_W+4 | Signed reference, FRAC_W fractional bits, one unit = one level step |
| pol_o | output | 1 | Polarity switch, 1 for negative output |
| minor_o | output | 1 | Minor-step switch |
| minor_n_o | output | 1 | Complement of the minor-step switch |
| cell_hi_o | output | 1 | Upper cell switch |
| cell_lo_o | output | 1 | Lower cell switch |

## Verification
The case to watch is the reference load at the carrier top landing on the same edge as a scheduled output update. That edge must still show the old level, and the new value appears one edge later. The bench provokes this by aligning a step from 0 to +5 one cycle after a load. It then requires level 0 for exactly one period minus one cycle, followed by level 5. Separately, the folding for negative values must coincide correctly with the even/odd split. This is judged through the exact period sum, the per-cycle floor/ceil band and the single-state encodings at ±4, ±5 and negative zero.

// File: rtl/ml11_pkg.sv
package ml11_pkg;
  localparam int unsigned NUM_MAG  = 5;
  localparam int unsigned NUM_CELL = 2;
  localparam int unsigned MAX_STEP = 5;

  typedef struct packed {
    logic pol;
    logic minor;
    logic minor_n;
    logic cell_hi;
    logic cell_lo;
  } sw_state_t;

  localparam sw_state_t SW_ZERO = '{pol: 1'b0, minor: 1'b0, minor_n: 1'b1,
                                    cell_hi: 1'b0, cell_lo: 1'b0};
endpackage

// File: rtl/ml11_carrier_gen.sv
module ml11_carrier_gen
  import ml11_pkg::*;
#(
  parameter int unsigned FRAC_W = 4,
  localparam int unsigned PH_W  = FRAC_W + 1
) (
  input  logic                                clk_i,
  input  logic                                rst_ni,
  output logic                                peak_o,
  output logic [NUM_MAG-1:0][FRAC_W-1:0]      mag_carr_o,
  output logic [NUM_CELL-1:0][FRAC_W-1:0]     cell_carr_o
);
  localparam int unsigned PER  = 2 ** PH_W;
  localparam int unsigned HALF = 2 ** FRAC_W;

  logic [PH_W-1:0] ph_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) ph_q <= '0;
    else         ph_q <= ph_q + 1'b1;
  end

  assign peak_o = (ph_q == PH_W'(HALF - 1));

  // triangle: rising over first half, mirrored over second half, 0..HALF-1
  for (genvar m = 0; m < NUM_MAG; m++) begin : g_mag
    localparam int unsigned OFF = (m * PER) / NUM_MAG;
    logic [PH_W-1:0] sh;
    assign sh            = ph_q + PH_W'(OFF);
    assign mag_carr_o[m] = sh[FRAC_W] ? ~sh[FRAC_W-1:0] : sh[FRAC_W-1:0];
  end

  for (genvar c = 0; c < NUM_CELL; c++) begin : g_cell
    localparam int unsigned OFF = (c * PER) / NUM_CELL;
    logic [PH_W-1:0] sh;
    assign sh             = ph_q + PH_W'(OFF);
    assign cell_carr_o[c] = sh[FRAC_W] ? ~sh[FRAC_W-1:0] : sh[FRAC_W-1:0];
  end
endmodule

// File: rtl/ml11_quantizer.sv
module ml11_quantizer
  import ml11_pkg::*;
#(
  parameter int unsigned FRAC_W = 4,
  localparam int unsigned MAG_W = FRAC_W + 4
) (
  input  logic                            clk_i,
  input  logic                            rst_ni,
  input  logic [MAG_W-1:0]                mag_i,
  input  logic [NUM_MAG-1:0][FRAC_W-1:0]  carr_i,
  output logic [2:0]                      stair_o
);
  localparam int unsigned HALF  = 2 ** FRAC_W;
  localparam int unsigned MAG_MAX = MAX_STEP * HALF;

  logic [MAG_W-1:0]   mag_sat;
  logic [NUM_MAG-1:0] cmp;

  assign mag_sat = (mag_i > MAG_W'(MAG_MAX)) ? MAG_W'(MAG_MAX) : mag_i;

  // carrier m lives in band [m*HALF, (m+1)*HALF)
  for (genvar m = 0; m < NUM_MAG; m++) begin : g_cmp
    logic [MAG_W-1:0] thr;
    assign thr    = MAG_W'(m * HALF) + MAG_W'(carr_i[m]);
    assign cmp[m] = mag_sat > thr;
  end

  always_comb begin
    stair_o = '0;
    for (int i = 0; i < NUM_MAG; i++) stair_o = stair_o + 3'(cmp[i]);
  end

  AST_STAIR_BAND: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (MAG_W'(stair_o) >= (mag_sat >> FRAC_W)) &&
    (MAG_W'(stair_o) <= ((mag_sat + MAG_W'(HALF - 1)) >> FRAC_W))); // R3

  AST_SAT_TOP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mag_i >= MAG_W'(MAG_MAX)) |-> (stair_o == 3'(MAX_STEP))); // R5
endmodule

// File: rtl/ml11_splitter.sv
module ml11_splitter
  import ml11_pkg::*;
(
  input  logic       neg_i,
  input  logic [2:0] stair_i,
  output logic [1:0] major_half_o,
  output logic       minor_o
);
  logic [2:0] fold;

  // negative side is offset into 0..5 so the even/odd split is uniform
  assign fold         = neg_i ? (3'(MAX_STEP) - stair_i) : stair_i;
  assign major_half_o = fold[2:1];
  assign minor_o      = fold[0];
endmodule

// File: rtl/ml11_cell_mod.sv
module ml11_cell_mod
  import ml11_pkg::*;
#(
  parameter int unsigned FRAC_W = 4
) (
  input  logic                             clk_i,
  input  logic                             rst_ni,
  input  logic [1:0]                       major_half_i,
  input  logic [NUM_CELL-1:0][FRAC_W-1:0]  carr_i,
  output logic                             cell_hi_o,
  output logic                             cell_lo_o
);
  logic [FRAC_W+1:0] lvl_w;

  // major_half*HALF against 2*carrier; two carriers half a period apart
  assign lvl_w     = {major_half_i, {FRAC_W{1'b0}}};
  assign cell_lo_o = lvl_w > {1'b0, carr_i[0], 1'b0};
  assign cell_hi_o = lvl_w > {1'b0, carr_i[1], 1'b0};

  AST_CELL_SUM: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ({1'b0, cell_hi_o} + {1'b0, cell_lo_o}) == major_half_i); // R9
endmodule

// File: rtl/ml11_modulator.sv
module ml11_modulator
  import ml11_pkg::*;
#(
  parameter int unsigned FRAC_W = 4,
  localparam int unsigned REF_W = FRAC_W + 4
) (
  input  logic                    clk_i,
  input  logic                    rst_ni,
  input  logic signed [REF_W-1:0] ref_i,
  output logic                    pol_o,
  output logic                    minor_o,
  output logic                    minor_n_o,
  output logic                    cell_hi_o,
  output logic                    cell_lo_o
);
  logic                               peak;
  logic [NUM_MAG-1:0][FRAC_W-1:0]     mag_carr;
  logic [NUM_CELL-1:0][FRAC_W-1:0]    cell_carr;
  logic signed [REF_W-1:0]            ref_q;
  logic                               neg;
  logic [REF_W-1:0]                   mag;
  logic [2:0]                         stair;
  logic [1:0]                         major_half;
  logic                               minor;
  logic                               c_hi, c_lo;
  sw_state_t                          sw_d, sw_q;

  ml11_carrier_gen #(.FRAC_W(FRAC_W)) u_carr (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .peak_o     (peak),
    .mag_carr_o (mag_carr),
    .cell_carr_o(cell_carr)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)   ref_q <= '0;
    else if (peak) ref_q <= ref_i;
  end

  assign neg = ref_q[REF_W-1];
  assign mag = neg ? ((~ref_q) + {{(REF_W-1){1'b0}}, 1'b1}) : ref_q;

  ml11_quantizer #(.FRAC_W(FRAC_W)) u_quant (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .mag_i  (mag),
    .carr_i (mag_carr),
    .stair_o(stair)
  );

  ml11_splitter u_split (
    .neg_i       (neg),
    .stair_i     (stair),
    .major_half_o(major_half),
    .minor_o     (minor)
  );

  ml11_cell_mod #(.FRAC_W(FRAC_W)) u_cell (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .major_half_i(major_half),
    .carr_i      (cell_carr),
    .cell_hi_o   (c_hi),
    .cell_lo_o   (c_lo)
  );

  always_comb begin
    sw_d.pol     = neg;
    sw_d.minor   = minor;
    sw_d.minor_n = ~minor;
    sw_d.cell_hi = c_hi;
    sw_d.cell_lo = c_lo;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) sw_q <= SW_ZERO;
    else         sw_q <= sw_d;
  end

  assign pol_o     = sw_q.pol;
  assign minor_o   = sw_q.minor;
  assign minor_n_o = sw_q.minor_n;
  assign cell_hi_o = sw_q.cell_hi;
  assign cell_lo_o = sw_q.cell_lo;

  AST_REF_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !peak |=> $stable(ref_q)); // R2

  AST_POL_SIGN: assert property (@(posedge clk_i) disable iff (!rst_ni)
    1'b1 |=> (pol_o == $past(ref_q[REF_W-1]))); // R6
endmodule

// File: tb/sim_ml11_modulator.sv
module sim_ml11_modulator;
  localparam int FRAC_W = 4;
  localparam int REF_W  = FRAC_W + 4;
  localparam int HALF   = 2 ** FRAC_W;
  localparam int PER    = 2 * HALF;
  localparam int MAXR   = 5 * HALF;

  logic clk = 1'b0;
  logic rst_ni = 1'b0;
  logic signed [REF_W-1:0] ref_i = '0;
  logic pol_o, minor_o, minor_n_o, cell_hi_o, cell_lo_o;

  int n_chk = 0;
  int n_bad = 0;
  int edge_cnt = 0;

  typedef struct { int rv; int exp_sum; } item_t;
  item_t sb_q[$];

  always #5 clk = ~clk;

  always @(posedge clk) if (rst_ni) edge_cnt <= edge_cnt + 1;

  ml11_modulator #(.FRAC_W(FRAC_W)) u0 (
    .clk_i(clk), .rst_ni(rst_ni), .ref_i(ref_i),
    .pol_o(pol_o), .minor_o(minor_o), .minor_n_o(minor_n_o),
    .cell_hi_o(cell_hi_o), .cell_lo_o(cell_lo_o)
  );

  function automatic int level();
    return 2 * (int'(cell_hi_o) + int'(cell_lo_o)) + int'(minor_o) - 5 * int'(pol_o);
  endfunction

  function automatic int clampr(int v);
    return (v > MAXR) ? MAXR : ((v < -MAXR) ? -MAXR : v);
  endfunction

  task automatic chk(bit ok, string req, int act, int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic summary();
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
  endtask

  // driver: apply, let two periods settle, hand one window to the monitor
  task automatic apply(int rv);
    item_t it;
    @(negedge clk);
    ref_i = REF_W'(rv);
    repeat (2 * PER) @(negedge clk);
    it.rv = rv;
    it.exp_sum = 2 * clampr(rv);
    sb_q.push_back(it);
    wait (sb_q.size() == 0);
  endtask

  // monitor
  initial begin
    forever begin
      int sum, c01, c10, m, lo, hi, lv, st;
      wait (sb_q.size() > 0);
      sum = 0; c01 = 0; c10 = 0;
      m  = clampr(sb_q[0].rv); m = (m < 0) ? -m : m;
      lo = m / HALF;
      hi = (m + HALF - 1) / HALF;
      for (int i = 0; i < PER; i++) begin
        @(negedge clk);
        lv = level();
        sum += lv;
        st = {pol_o, minor_o, cell_hi_o, cell_lo_o};
        if ({cell_hi_o, cell_lo_o} == 2'b01) c01++;
        if ({cell_hi_o, cell_lo_o} == 2'b10) c10++;
        chk(minor_n_o != minor_o, "R7 minor complement", minor_n_o, !minor_o);
        chk(((lv < 0 ? -lv : lv) >= lo) && ((lv < 0 ? -lv : lv) <= hi),
            "R3 level band", lv, (sb_q[0].rv < 0) ? -lo : lo);
        chk(pol_o == (sb_q[0].rv < 0), "R6 polarity", pol_o, sb_q[0].rv < 0);
        if (sb_q[0].rv > MAXR)  chk(lv == 5,  "R5 positive saturation", lv, 5);
        if (sb_q[0].rv < -MAXR) chk(lv == -5, "R5 negative saturation", lv, -5);
        if (sb_q[0].rv == 80)   chk(st == 4'b0111, "R8 state +5", st, 4'b0111);
        if (sb_q[0].rv == -80)  chk(st == 4'b1000, "R8 state -5", st, 4'b1000);
        if (sb_q[0].rv == 64)   chk(st == 4'b0011, "R8 state +4", st, 4'b0011);
        if (sb_q[0].rv == -64)  chk(st == 4'b1100, "R8 state -4", st, 4'b1100);
        if (sb_q[0].rv < 0 && lv == 0)
          chk(st == 4'b1111, "R8 negative zero state", st, 4'b1111);
      end
      chk(sum == sb_q[0].exp_sum, "R4 period sum", sum, sb_q[0].exp_sum);
      if (sb_q[0].rv == 32 || sb_q[0].rv == -48) begin
        chk(c01 == HALF, "R9 cell state 01 share", c01, HALF);
        chk(c10 == HALF, "R9 cell state 10 share", c10, HALF);
      end
      void'(sb_q.pop_front());
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog: actual 0 expected 1");
    summary();
    $finish;
  end

  initial begin
    int refs[14] = '{0, 80, -80, 64, -64, 32, -48, 40, -8, -27, 127, -128, 5, -1};
    repeat (3) @(negedge clk);
    // R1 reset values
    chk({pol_o, minor_o, minor_n_o, cell_hi_o, cell_lo_o} == 5'b00100,
        "R1 reset state", {pol_o, minor_o, minor_n_o, cell_hi_o, cell_lo_o}, 5'b00100);
    rst_ni = 1'b1;
    foreach (refs[i]) apply(refs[i]);
    apply(0);
    // R2: step one cycle after a load; old level must hold PER-1 cycles
    do @(negedge clk); while ((edge_cnt % PER) != ((HALF + 1) % PER));
    ref_i = REF_W'(80);
    for (int i = 0; i < PER - 1; i++) begin
      @(negedge clk);
      chk(level() == 0, "R2 hold until next load", level(), 0);
    end
    @(negedge clk);
    chk(level() == 5, "R2 new reference applied", level(), 5);
    summary();
    $finish;
  end
endmodule